// File: doc/BRIEF.md
# Remote Terminal Lookup Address Generator

This block works out every memory address that a remote terminal needs to handle one bus message. It takes the received command word and breaks out three fields: the transmit/receive bit, the 5-bit subaddress and the word count. With an optional broadcast qualifier, the first two form a lookup-table index. A global area-select input picks one of two complete sets of data structures. Each set has its own stack pointer and its own lookup table, and switching the input swaps both together.

Per message, the block runs a fixed sequence against a single-port memory:
1. It reads the active stack pointer.
2. It stores the command word in the fourth word of the four-word message descriptor.
3. It writes the advanced stack pointer back.
4. It reads the lookup-table entry that points to the data block.
5. It emits one data address per word, from one up to 32, on a valid/ready stream.

In single-message mode the block never changes the lookup entry. Every message to a subaddress therefore reuses the same data block, which is overwritten on receive and re-read on transmit.

Commands enter on a valid/ready port, and the block takes a new one only when it is idle. Memory requests use valid/ready with at most one read outstanding. A read response is a one-cycle pulse and cannot be back-pressured. The data-address stream may be stalled by its consumer for any number of cycles.

Top module: `rt_lookup_addr_gen`

## Requirements
- R1: `cmd_ready` is high exactly when no message is in progress. After reset it is high. It goes low in the cycle after a command is accepted and returns high in the cycle after the final data address is accepted. `area_sel`, `bcast_split_en` and `cmd_bcast` are sampled only at acceptance, so later changes to them during a message have no effect on its addresses. While `cmd_ready` is high, neither `mem_req_valid` nor `dat_valid` is asserted.
- R2: The first memory request of a message is a read of the stack pointer. Its address is 0x0100 for area 0 and 0x0104 for area 1.
- R3: The second request writes the command word to the fourth descriptor word. That address is the stack pointer plus 3, where the addition wraps inside the 256-word page: the upper 8 bits are kept and the low 8 bits wrap.
- R4: The third request writes the stack pointer plus 4 to the stack-pointer address of the active area. The addition wraps in the same way as R3.
- R5: The fourth request reads the lookup entry at 0x0180 + 0x80×area + index. In the index, bits 4:0 are the subaddress (command bits 9:5) and bit 5 is the T/R bit (command bit 10). Bit 6 equals `cmd_bcast` when `bcast_split_en` is 1 and is 0 otherwise. Command bits 15:11 are ignored.
- R6: After the lookup response, the data stream carries the addresses ptr, ptr+1, and so on, modulo 2^16, where ptr is the lookup entry. There are N of them, with N equal to command bits 4:0, or 32 when that field is 0. `dat_last` is high only on the Nth address.
- R7: While `dat_valid` is high and `dat_ready` is low, `dat_valid`, `dat_addr` and `dat_last` hold their values.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, direction and write data hold their values. No request is issued while a read is awaiting its response, and no request is issued while data addresses are being streamed.
- R9: The lookup entry is only read, never written, so repeated messages to the same subaddress with unchanged memory give identical data addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| area_sel | input | 1 | Global choice between data-structure set 0 and set 1 |
| bcast_split_en | input | 1 | When 1, the broadcast flag becomes index bit 6 |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block is idle and takes the command |
| cmd_word | input | 16 | Received command word |
| cmd_bcast | input | 1 | Command was addressed to broadcast |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Request word address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | One-cycle read response strobe |
| mem_rsp_data | input | 16 | Read data |
| dat_valid | output | 1 | Data-word address offered |
| dat_ready | input | 1 | Consumer takes the data address |
| dat_addr | output | 16 | Data-word address |
| dat_last | output | 1 | Final address of the message |

## Verification
The bench targets five corner cases:
- A word count of zero must yield 32 addresses. A design that treats zero literally would emit none or would run past 32.
- Stack pointers at 0x00FC and 0x00FE must wrap inside their page. A plain 16-bit add would write the command word and the new stack pointer outside the stack region.
- A data pointer near 0xFFFF checks that the address wraps.
- Toggling the area select, the broadcast-split enable and the broadcast flag in mid-message catches a design that reads them live instead of latching them. Such a design would move its writeback or lookup to the wrong table.
- Random back-pressure on both the memory and data ports, together with variable read latency, catches a design that drops a stalled address or issues the next request before the read response.

// File: rtl/rtla_pkg.sv
package rtla_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SP_RD,
    ST_SP_WAIT,
    ST_CMD_WR,
    ST_SP_WR,
    ST_LUT_RD,
    ST_LUT_WAIT,
    ST_DATA
  } seq_state_t;

  typedef struct packed {
    logic [4:0] term_addr;
    logic       xmit;
    logic [4:0] subaddr;
    logic [4:0] word_cnt;
  } cmd_word_t;

  localparam int DESC_WORDS = 4;
  localparam int CMD_SLOT   = 3;

endpackage

// File: rtl/rtla_index.sv
module rtla_index #(
  parameter int AW = 16,
  parameter int SA_W = 5,
  parameter logic [AW-1:0] SP_BASE = 16'h0100,
  parameter logic [AW-1:0] SP_AREA_STEP = 16'h0004,
  parameter logic [AW-1:0] LUT_BASE = 16'h0180,
  parameter logic [AW-1:0] LUT_AREA_STEP = 16'h0080
) (
  input  logic            area,
  input  logic            bc_qual,
  input  logic            xmit,
  input  logic [SA_W-1:0] subaddr,
  output logic [AW-1:0]   sp_addr,
  output logic [AW-1:0]   lut_addr
);
  localparam int IDX_W = SA_W + 2;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx      = {bc_qual, xmit, subaddr};
    sp_addr  = SP_BASE + (area ? SP_AREA_STEP : '0);
    lut_addr = LUT_BASE + (area ? LUT_AREA_STEP : '0) + AW'(idx);
  end
endmodule

// File: rtl/rtla_stack_step.sv
module rtla_stack_step #(
  parameter int AW = 16,
  parameter int STACK_W = 8
) (
  input  logic [AW-1:0] sp,
  output logic [AW-1:0] slot_addr,
  output logic [AW-1:0] next_sp
);
  import rtla_pkg::*;

  logic [STACK_W-1:0] lo_slot, lo_next;

  always_comb begin
    lo_slot   = sp[STACK_W-1:0] + STACK_W'(CMD_SLOT);
    lo_next   = sp[STACK_W-1:0] + STACK_W'(DESC_WORDS);
    slot_addr = {sp[AW-1:STACK_W], lo_slot};
    next_sp   = {sp[AW-1:STACK_W], lo_next};
  end
endmodule

// File: rtl/rtla_burst.sv
module rtla_burst #(
  parameter int AW = 16,
  parameter int MAX_WORDS = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [AW-1:0]                base,
  input  logic [$clog2(MAX_WORDS)-1:0] wc_field,
  output logic                         dat_valid,
  input  logic                         dat_ready,
  output logic [AW-1:0]                dat_addr,
  output logic                         dat_last,
  output logic                         done
);
  localparam int WC_W = $clog2(MAX_WORDS);
  localparam int CW   = $clog2(MAX_WORDS + 1);

  logic          active;
  logic [AW-1:0] base_q;
  logic [CW-1:0] idx_q, tot_q, total;

  always_comb begin
    total     = (wc_field == '0) ? CW'(MAX_WORDS) : CW'(wc_field);
    dat_valid = active;
    dat_addr  = base_q + AW'(idx_q);
    dat_last  = active && (idx_q == tot_q - CW'(1));
    done      = active && dat_ready && dat_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      tot_q  <= CW'(1);
    end else if (start) begin
      active <= 1'b1;
      base_q <= base;
      idx_q  <= '0;
      tot_q  <= total;
    end else if (active && dat_ready) begin
      if (dat_last) active <= 1'b0;
      else          idx_q  <= idx_q + CW'(1);
    end
  end

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && !dat_ready |=> dat_valid && $stable(dat_addr) && $stable(dat_last));

  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !dat_valid);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> (tot_q >= CW'(1)) && (tot_q <= CW'(MAX_WORDS)) && (idx_q < tot_q));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> !start);

  logic unused_wcw;
  assign unused_wcw = ^WC_W;
endmodule

// File: rtl/rt_lookup_addr_gen.sv
module rt_lookup_addr_gen #(
  parameter int AW = 16,
  parameter int SA_W = 5,
  parameter int MAX_WORDS = 32,
  parameter int STACK_W = 8,
  parameter logic [AW-1:0] SP_BASE = 16'h0100,
  parameter logic [AW-1:0] SP_AREA_STEP = 16'h0004,
  parameter logic [AW-1:0] LUT_BASE = 16'h0180,
  parameter logic [AW-1:0] LUT_AREA_STEP = 16'h0080
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          area_sel,
  input  logic          bcast_split_en,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [15:0]   cmd_word,
  input  logic          cmd_bcast,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [AW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          dat_valid,
  input  logic          dat_ready,
  output logic [AW-1:0] dat_addr,
  output logic          dat_last
);
  import rtla_pkg::*;

  seq_state_t    state;
  cmd_word_t     cmd_q;
  logic          area_q, bc_q;
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_addr, lut_addr, slot_addr, next_sp;
  logic          burst_start, burst_done;

  rtla_index #(
    .AW(AW), .SA_W(SA_W), .SP_BASE(SP_BASE), .SP_AREA_STEP(SP_AREA_STEP),
    .LUT_BASE(LUT_BASE), .LUT_AREA_STEP(LUT_AREA_STEP)
  ) u_index (
    .area(area_q), .bc_qual(bc_q), .xmit(cmd_q.xmit), .subaddr(cmd_q.subaddr),
    .sp_addr(sp_addr), .lut_addr(lut_addr)
  );

  rtla_stack_step #(.AW(AW), .STACK_W(STACK_W)) u_step (
    .sp(sp_q), .slot_addr(slot_addr), .next_sp(next_sp)
  );

  assign burst_start = (state == ST_LUT_WAIT) && mem_rsp_valid;

  rtla_burst #(.AW(AW), .MAX_WORDS(MAX_WORDS)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(burst_start), .base(mem_rsp_data),
    .wc_field(cmd_q.word_cnt), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_addr(dat_addr), .dat_last(dat_last), .done(burst_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cmd_q  <= '0;
      area_q <= 1'b0;
      bc_q   <= 1'b0;
      sp_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          cmd_q  <= cmd_word_t'(cmd_word);
          area_q <= area_sel;
          bc_q   <= cmd_bcast & bcast_split_en;
          state  <= ST_SP_RD;
        end
        ST_SP_RD:    if (mem_req_ready) state <= ST_SP_WAIT;
        ST_SP_WAIT:  if (mem_rsp_valid) begin
          sp_q  <= mem_rsp_data;
          state <= ST_CMD_WR;
        end
        ST_CMD_WR:   if (mem_req_ready) state <= ST_SP_WR;
        ST_SP_WR:    if (mem_req_ready) state <= ST_LUT_RD;
        ST_LUT_RD:   if (mem_req_ready) state <= ST_LUT_WAIT;
        ST_LUT_WAIT: if (mem_rsp_valid) state <= ST_DATA;
        ST_DATA:     if (burst_done)    state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready     = (state == ST_IDLE);
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    unique case (state)
      ST_SP_RD:  begin mem_req_valid = 1'b1; mem_req_addr = sp_addr; end
      ST_CMD_WR: begin
        mem_req_valid = 1'b1; mem_req_we = 1'b1;
        mem_req_addr  = slot_addr; mem_req_wdata = AW'(cmd_q);
      end
      ST_SP_WR:  begin
        mem_req_valid = 1'b1; mem_req_we = 1'b1;
        mem_req_addr  = sp_addr; mem_req_wdata = next_sp;
      end
      ST_LUT_RD: begin mem_req_valid = 1'b1; mem_req_addr = lut_addr; end
      default: ;
    endcase
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid && !dat_valid);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> !mem_req_valid);

  assert_read_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && !mem_req_we |=> !mem_req_valid);

  assert_lut_in_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LUT_RD) |-> (mem_req_addr >= LUT_BASE)
      && (mem_req_addr < LUT_BASE + LUT_AREA_STEP + LUT_AREA_STEP));

  assert_stack_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD_WR) |-> mem_req_addr[AW-1:STACK_W] == sp_q[AW-1:STACK_W]);
endmodule

// File: tb/rt_lookup_addr_gen_tb.sv
module rt_lookup_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        area_sel = 1'b0, bcast_split_en = 1'b0;
  logic        cmd_valid = 1'b0, cmd_bcast = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        cmd_ready;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        dat_valid, dat_last;
  logic        dat_ready = 1'b0;
  logic [15:0] dat_addr;

  always #5 clk = ~clk;

  rt_lookup_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .area_sel(area_sel), .bcast_split_en(bcast_split_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_bcast(cmd_bcast),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_addr(dat_addr), .dat_last(dat_last)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] mem [0:1023];
  logic [32:0] exp_req [$];
  logic [16:0] exp_dat [$];
  bit model_idle = 1'b1;
  bit bp_mem = 1'b0, bp_dat = 1'b0;
  bit hs_req = 1'b0, hs_we = 1'b0;
  logic [15:0] hs_addr = '0, hs_data = '0;
  bit prev_stall = 1'b0;
  logic [15:0] prev_addr = '0;
  bit rd_pend = 1'b0;
  int rd_lat = 0;
  logic [15:0] rd_addr = '0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] page_add(logic [15:0] sp, int k);
    return {sp[15:8], 8'(sp[7:0] + 8'(k))};
  endfunction

  // reference model: expectations built at command acceptance
  always @(negedge clk) begin
    hs_req = 1'b0;
    if (!rst_n) begin
      chk(cmd_ready === 1'b1, "R1", "reset cmd_ready", 32'(cmd_ready), 1);
      chk(mem_req_valid === 1'b0 && dat_valid === 1'b0, "R1", "reset valids",
          {30'd0, mem_req_valid, dat_valid}, 0);
    end else begin
      chk(cmd_ready === model_idle, "R1", "cmd_ready", 32'(cmd_ready), 32'(model_idle));
      if (cmd_ready) chk(!mem_req_valid && !dat_valid, "R1", "idle quiet",
                         {30'd0, mem_req_valid, dat_valid}, 0);
      if (prev_stall) chk(dat_valid && dat_addr == prev_addr, "R7", "stalled addr held",
                          {15'd0, dat_valid, dat_addr}, {16'd1, prev_addr});
      prev_stall = dat_valid && !dat_ready;
      prev_addr  = dat_addr;
      if (mem_req_valid && mem_req_ready) begin
        hs_req = 1'b1; hs_we = mem_req_we; hs_addr = mem_req_addr; hs_data = mem_req_wdata;
        if (exp_req.size() == 0) chk(0, "R8", "unexpected request", 32'(mem_req_addr), 0);
        else begin
          logic [32:0] e;
          e = exp_req.pop_front();
          chk(mem_req_we == e[32] && mem_req_addr == e[31:16], "R2 R3 R4 R5",
              "request dir/addr", {15'd0, mem_req_we, mem_req_addr}, {15'd0, e[32:16]});
          if (e[32]) chk(mem_req_wdata == e[15:0], "R3 R4", "write data",
                         32'(mem_req_wdata), 32'(e[15:0]));
        end
      end
      if (dat_valid && dat_ready) begin
        if (exp_dat.size() == 0) chk(0, "R6", "unexpected data addr", 32'(dat_addr), 0);
        else begin
          logic [16:0] d;
          d = exp_dat.pop_front();
          chk(dat_addr == d[15:0] && dat_last == d[16], "R6 R9", "data addr/last",
              {15'd0, dat_last, dat_addr}, {15'd0, d});
          if (d[16]) model_idle = 1'b1;
        end
      end
      if (cmd_valid && cmd_ready) begin
        logic [15:0] spa, lut, sp, ptr;
        logic [6:0] idx;
        int n;
        model_idle = 1'b0;
        spa = 16'h0100 + (area_sel ? 16'h0004 : 16'h0000);
        idx = {cmd_bcast & bcast_split_en, cmd_word[10], cmd_word[9:5]};
        lut = 16'h0180 + (area_sel ? 16'h0080 : 16'h0000) + 16'(idx);
        sp  = mem[spa[9:0]];
        ptr = mem[lut[9:0]];
        n   = (cmd_word[4:0] == 0) ? 32 : int'(cmd_word[4:0]);
        exp_req.push_back({1'b0, spa, 16'h0});
        exp_req.push_back({1'b1, page_add(sp, 3), cmd_word});
        exp_req.push_back({1'b1, spa, page_add(sp, 4)});
        exp_req.push_back({1'b0, lut, 16'h0});
        for (int i = 0; i < n; i++) exp_dat.push_back({i == n - 1, 16'(ptr + 16'(i))});
      end
    end
  end

  // memory and back-pressure driver
  always @(posedge clk) begin
    #1;
    mem_rsp_valid <= 1'b0;
    if (hs_req) begin
      if (hs_we) mem[hs_addr[9:0]] = hs_data;
      else begin rd_pend = 1'b1; rd_addr = hs_addr; rd_lat = int'($urandom % 3); end
    end
    if (rd_pend) begin
      if (rd_lat == 0) begin
        mem_rsp_valid <= 1'b1; mem_rsp_data <= mem[rd_addr[9:0]]; rd_pend = 1'b0;
      end else rd_lat--;
    end
    mem_req_ready <= bp_mem ? ($urandom % 3 != 0) : 1'b1;
    dat_ready     <= bp_dat ? ($urandom % 2 != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(bit area, bit split, bit bc, bit tr, logic [4:0] sa, logic [4:0] wc,
                      logic [15:0] sp, logic [15:0] ptr, bit disturb);
    logic [15:0] spa, lut;
    spa = 16'h0100 + (area ? 16'h0004 : 16'h0000);
    lut = 16'h0180 + (area ? 16'h0080 : 16'h0000) + 16'({bc & split, tr, sa});
    @(posedge clk); #2;
    mem[spa[9:0]] = sp;
    mem[lut[9:0]] = ptr;
    area_sel = area; bcast_split_en = split; cmd_bcast = bc;
    cmd_word = {5'(($urandom % 32)), tr, sa, wc};
    cmd_valid = 1'b1;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #2;
    cmd_valid = 1'b0;
    if (disturb) begin
      area_sel = ~area; bcast_split_en = ~split; cmd_bcast = ~bc; cmd_word = ~cmd_word;
    end
    do @(negedge clk); while (!model_idle);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 7);
    repeat (3) @(negedge clk);
    @(posedge clk); #2 rst_n = 1'b1;
    // R2 R3 R4 R5 R6: area 0 receive, plain
    send(0, 0, 0, 0, 5'd3, 5'd4, 16'h0010, 16'h0300, 0);
    // R2 R5 R6: area 1 transmit, word count zero means 32, back-pressure (R7 R8)
    bp_mem = 1; bp_dat = 1;
    send(1, 0, 0, 1, 5'd30, 5'd0, 16'h0020, 16'h0340, 0);
    // R3 R4: stack page wrap; R6: data address wrap; R5 broadcast bit 6
    send(0, 1, 1, 0, 5'd5, 5'd3, 16'h00FC, 16'hFFFE, 0);
    // R5: broadcast ignored when split disabled; R3 wrap from 0x00FE
    send(1, 0, 1, 1, 5'd31, 5'd2, 16'h00FE, 16'h0123, 0);
    // R1: inputs toggled mid-message have no effect
    send(0, 1, 1, 1, 5'd9, 5'd6, 16'h0044, 16'h0200, 1);
    // R9: same subaddress twice yields same block
    send(1, 1, 0, 0, 5'd12, 5'd1, 16'h0080, 16'h0777, 0);
    send(1, 1, 0, 0, 5'd12, 5'd1, 16'h0080, 16'h0777, 0);
    for (int k = 0; k < 24; k++)
      send(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom),
           5'($urandom), {8'h00, 8'($urandom)}, 16'($urandom), 1'($urandom));
    bp_mem = 0; bp_dat = 0;
    send(0, 0, 0, 0, 5'd1, 5'd1, 16'h0000, 16'h0001, 0);
    repeat (5) @(negedge clk);
    chk(exp_req.size() == 0 && exp_dat.size() == 0, "R6 R8", "all expectations consumed",
        32'(exp_req.size() + exp_dat.size()), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule